// File: doc/BRIEF.md
# SRAM Split-Line Permission Guard

This block sits beside the on-chip SRAM and judges every access against a region map that software programs. The covered SRAM is three consecutive segments placed directly above a reserved cache window. Five movable boundaries divide it at 512-byte granularity. One boundary is shared by the instruction and data views, and each view has two more of its own. In each view, three boundaries cut the covered range into four areas. Every area has its own permission field: read, write and execute in the instruction view, and read and write in the data view.

An access presents a byte offset, a view (instruction or data) and a kind (load, store or fetch). The allow output is produced in the same cycle, with no register on the request path. Configuration goes through a single register port. Writes take effect at the clock edge, and reads are combinational. Two sticky locks freeze the configuration: one for the boundaries and one for the permissions. Only a reset clears them.

When software writes a boundary register, it gives only the line number. The block then works out for itself which segment holds the line and stores a 2-bit code for each segment alongside it. Writes that would place a boundary outside the covered segments are dropped.

Top module: `sram_perm_guard`

## Requirements
- R1: After reset every configuration register reads 0: locks clear, all five boundary lines at 0 with category codes 0, and all permission bits clear. A covered access is therefore denied.
- R2: Register indices 1 to 5 hold the boundaries (1 shared, 2 and 3 instruction low/high, 4 and 5 data low/high). A write stores the line number from write-data bits [16:6] (byte offset divided by 512) only when the line's byte offset lies in [0x4000, 0x64000). Any other value leaves the register unchanged.
- R3: Each boundary register reads back its line in bits [16:6] and three category codes computed by the block: bits [1:0] for segment 0, [3:2] for segment 1 and [5:4] for segment 2. The segment containing the line reads 2, a segment starting above the line reads 3, and a segment ending at or below the line reads 0. Written category bits are ignored.
- R4: The area of a covered access is the number of its view's three boundaries whose line is at or below the access's byte offset divided by 512. The instruction view uses (instruction low, instruction high, shared) and the data view uses (shared, data low, data high).
- R5: Index 7 holds the instruction permissions, with area n in bits [3n+2:3n]: bit 0 load, bit 1 store, bit 2 fetch. Index 8 holds the data permissions, with area n in bits [2n+1:2n]: bit 0 load, bit 1 store.
- R6: A covered access is allowed exactly when its area's bit for its kind is set. Kind codes are load 0, store 1, fetch 2. Kind 3 is always denied, and a fetch through the data view is always denied.
- R7: An access whose offset is below 0x4000 or at or above 0x64000 is allowed, whatever the configuration.
- R8: Writing 1 in bit 0 to index 0 sets the boundary lock, and writing 1 in bit 0 to index 6 sets the permission lock. Each lock reads back 1 in bit 0 once set. Writing 0 has no effect, and only reset clears a lock.
- R9: While the boundary lock is set, writes to indices 1 to 5 are ignored. While the permission lock is set, writes to indices 7 and 8 are ignored. Neither lock affects the other set of registers.
- R10: The allow output is combinational from the request and the current configuration. A configuration write changes the verdict only after the clock edge that stores it.
- R11: Indices 9 to 15 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register index (read and write) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr |
| req_addr | input | ADDR_W (20) | Byte offset of the access in the SRAM window |
| req_space | input | 1 | 0 instruction view, 1 data view |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| req_allow | output | 1 | 1 when the access is permitted |

## Verification
A configuration write and an access check can fall in the same cycle, and the access must be judged against the configuration as it stood before that write. The bench provokes this by driving a permission write together with a covered request whose verdict the write flips. It samples allow once before the clock edge and expects the old verdict, then samples again after the edge and expects the new one. Lock setting against a later write in the locked set is judged in the same way, both through read-back and through the allow output.

// File: rtl/spg_pkg.sv
package spg_pkg;

    // access kind: the code doubles as the permission bit position
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic {
        VIEW_INSTR = 1'b0,
        VIEW_DATA  = 1'b1
    } acc_view_e;

    localparam int REG_IDX_W = 4;

    localparam logic [REG_IDX_W-1:0] IDX_SPLIT_LOCK = 4'd0;
    localparam logic [REG_IDX_W-1:0] IDX_LINE_FIRST = 4'd1;
    localparam logic [REG_IDX_W-1:0] IDX_LINE_LAST  = 4'd5;
    localparam logic [REG_IDX_W-1:0] IDX_PERM_LOCK  = 4'd6;
    localparam logic [REG_IDX_W-1:0] IDX_PERM_INSTR = 4'd7;
    localparam logic [REG_IDX_W-1:0] IDX_PERM_DATA  = 4'd8;

    // boundary slots (slot = register index - 1)
    localparam int NUM_LINES  = 5;
    localparam int SLOT_W     = $clog2(NUM_LINES);
    localparam int SLOT_SHARE = 0;
    localparam int SLOT_ILO   = 1;
    localparam int SLOT_IHI   = 2;
    localparam int SLOT_DLO   = 3;
    localparam int SLOT_DHI   = 4;

    localparam int BOUNDS_PER_VIEW = 3;
    localparam int NUM_AREA  = BOUNDS_PER_VIEW + 1;
    localparam int AREA_W    = $clog2(NUM_AREA);
    localparam int IPERM_W   = 3;
    localparam int DPERM_W   = 2;

    localparam int CAT_W = 2;
    localparam logic [CAT_W-1:0] CAT_BELOW = 2'd0;
    localparam logic [CAT_W-1:0] CAT_HOME  = 2'd2;
    localparam logic [CAT_W-1:0] CAT_ABOVE = 2'd3;

    typedef struct packed {
        logic [AREA_W-1:0] area;
        logic              granted;
    } verdict_t;

    function automatic logic kind_is_data_legal(input acc_kind_e k);
        return (k == ACC_LOAD) || (k == ACC_STORE);
    endfunction

endpackage

// File: rtl/spg_split_bank.sv
module spg_split_bank
    import spg_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int LINE_SHIFT = 9,
    parameter int RSV_BYTES  = 16384,
    parameter int SEG_BYTES  = 131072,
    parameter int NUM_SEG    = 3,
    localparam int LINE_W    = ADDR_W - LINE_SHIFT,
    localparam int CATS_W    = CAT_W * NUM_SEG
)(
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr_en,
    input  logic [REG_IDX_W-1:0]                 wr_idx,
    input  logic                                 wr_lock_bit,
    input  logic [LINE_W-1:0]                    wr_line,
    output logic                                 lock_o,
    output logic [NUM_LINES-1:0][LINE_W-1:0]     line_o,
    output logic [NUM_LINES-1:0][CATS_W-1:0]     cats_o
);

    localparam logic [31:0] COVER_LO = 32'(RSV_BYTES);
    localparam logic [31:0] COVER_HI = 32'(RSV_BYTES + NUM_SEG * SEG_BYTES);

    function automatic logic [31:0] byte_of(input logic [LINE_W-1:0] ln);
        return 32'(ln) << LINE_SHIFT;
    endfunction

    function automatic logic target_ok(input logic [LINE_W-1:0] ln);
        return (byte_of(ln) >= COVER_LO) && (byte_of(ln) < COVER_HI);
    endfunction

    // per-segment code: containing segment, segments above, segments below
    function automatic logic [CATS_W-1:0] derive_cats(input logic [LINE_W-1:0] ln);
        logic [CATS_W-1:0] c;
        logic [31:0]       pos;
        c   = '0;
        pos = byte_of(ln);
        for (int s = 0; s < NUM_SEG; s++) begin
            if (pos >= 32'(RSV_BYTES + (s + 1) * SEG_BYTES))
                c[CAT_W*s +: CAT_W] = CAT_BELOW;
            else if (pos >= 32'(RSV_BYTES + s * SEG_BYTES))
                c[CAT_W*s +: CAT_W] = CAT_HOME;
            else
                c[CAT_W*s +: CAT_W] = CAT_ABOVE;
        end
        return c;
    endfunction

    logic              lock_q;
    logic              line_accept;
    logic [CATS_W-1:0] new_cats;

    assign line_accept = wr_en && !lock_q && target_ok(wr_line);
    assign new_cats    = derive_cats(wr_line);

    always_ff @(posedge clk) begin
        if (rst)
            lock_q <= 1'b0;
        else if (wr_en && (wr_idx == IDX_SPLIT_LOCK) && wr_lock_bit)
            lock_q <= 1'b1;
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam logic [REG_IDX_W-1:0] MY_IDX = IDX_LINE_FIRST + REG_IDX_W'(g);

        logic [LINE_W-1:0] line_q;
        logic [CATS_W-1:0] cats_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                line_q <= '0;
                cats_q <= '0;
            end else if (line_accept && (wr_idx == MY_IDX)) begin
                line_q <= wr_line;
                cats_q <= new_cats;
            end
        end

        assign line_o[g] = line_q;
        assign cats_o[g] = cats_q;
    end

    assign lock_o = lock_q;

endmodule

// File: rtl/spg_perm_bank.sv
module spg_perm_bank
    import spg_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [REG_IDX_W-1:0]              wr_idx,
    input  logic                              wr_lock_bit,
    input  logic [NUM_AREA*IPERM_W-1:0]       wr_iperm,
    input  logic [NUM_AREA*DPERM_W-1:0]       wr_dperm,
    output logic                              lock_o,
    output logic [NUM_AREA-1:0][IPERM_W-1:0]  iperm_o,
    output logic [NUM_AREA-1:0][DPERM_W-1:0]  dperm_o
);

    logic                             lock_q;
    logic [NUM_AREA-1:0][IPERM_W-1:0] iperm_q;
    logic [NUM_AREA-1:0][DPERM_W-1:0] dperm_q;
    logic                             open_wr;

    assign open_wr = wr_en && !lock_q;

    always_ff @(posedge clk) begin
        if (rst)
            lock_q <= 1'b0;
        else if (wr_en && (wr_idx == IDX_PERM_LOCK) && wr_lock_bit)
            lock_q <= 1'b1;
    end

    for (genvar a = 0; a < NUM_AREA; a++) begin : g_area
        always_ff @(posedge clk) begin
            if (rst) begin
                iperm_q[a] <= '0;
                dperm_q[a] <= '0;
            end else if (open_wr) begin
                if (wr_idx == IDX_PERM_INSTR)
                    iperm_q[a] <= wr_iperm[IPERM_W*a +: IPERM_W];
                if (wr_idx == IDX_PERM_DATA)
                    dperm_q[a] <= wr_dperm[DPERM_W*a +: DPERM_W];
            end
        end
    end

    assign lock_o  = lock_q;
    assign iperm_o = iperm_q;
    assign dperm_o = dperm_q;

endmodule

// File: rtl/spg_area_sel.sv
module spg_area_sel
    import spg_pkg::*;
#(
    parameter int LINE_W    = 11,
    parameter int NUM_BOUND = BOUNDS_PER_VIEW,
    localparam int IDX_W    = $clog2(NUM_BOUND + 1)
)(
    input  logic [LINE_W-1:0]                 addr_line,
    input  logic [NUM_BOUND-1:0][LINE_W-1:0]  bounds,
    output logic [IDX_W-1:0]                  area
);

    logic [NUM_BOUND-1:0] passed;

    for (genvar b = 0; b < NUM_BOUND; b++) begin : g_cmp
        assign passed[b] = (addr_line >= bounds[b]);
    end

    // counting the passed boundaries keeps the result monotone in the address
    always_comb begin
        area = '0;
        for (int b = 0; b < NUM_BOUND; b++)
            area = area + IDX_W'(passed[b]);
    end

endmodule

// File: rtl/sram_perm_guard.sv
module sram_perm_guard
    import spg_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int LINE_SHIFT = 9,
    parameter int RSV_BYTES  = 16384,
    parameter int SEG_BYTES  = 131072,
    parameter int NUM_SEG    = 3,
    parameter int DATA_W     = 32
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [REG_IDX_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_space,
    input  logic [1:0]           req_kind,
    output logic                 req_allow
);

    localparam int LINE_W  = ADDR_W - LINE_SHIFT;
    localparam int CATS_W  = CAT_W * NUM_SEG;
    localparam int LREG_W  = CATS_W + LINE_W;
    localparam logic [31:0] COVER_LO = 32'(RSV_BYTES);
    localparam logic [31:0] COVER_HI = 32'(RSV_BYTES + NUM_SEG * SEG_BYTES);

    logic                             split_lock;
    logic                             perm_lock;
    logic [NUM_LINES-1:0][LINE_W-1:0] line_val;
    logic [NUM_LINES-1:0][CATS_W-1:0] cat_val;
    logic [NUM_AREA-1:0][IPERM_W-1:0] iperm_val;
    logic [NUM_AREA-1:0][DPERM_W-1:0] dperm_val;
    logic                             wdata_unused;

    assign wdata_unused = ^cfg_wdata[DATA_W-1:LREG_W];

    spg_split_bank #(
        .ADDR_W     (ADDR_W),
        .LINE_SHIFT (LINE_SHIFT),
        .RSV_BYTES  (RSV_BYTES),
        .SEG_BYTES  (SEG_BYTES),
        .NUM_SEG    (NUM_SEG)
    ) u_split (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (cfg_we),
        .wr_idx      (cfg_addr),
        .wr_lock_bit (cfg_wdata[0]),
        .wr_line     (cfg_wdata[CATS_W +: LINE_W]),
        .lock_o      (split_lock),
        .line_o      (line_val),
        .cats_o      (cat_val)
    );

    spg_perm_bank u_perm (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (cfg_we),
        .wr_idx      (cfg_addr),
        .wr_lock_bit (cfg_wdata[0]),
        .wr_iperm    (cfg_wdata[NUM_AREA*IPERM_W-1:0]),
        .wr_dperm    (cfg_wdata[NUM_AREA*DPERM_W-1:0]),
        .lock_o      (perm_lock),
        .iperm_o     (iperm_val),
        .dperm_o     (dperm_val)
    );

    // ---------------- access path ----------------
    logic [LINE_W-1:0]                          req_line;
    logic                                       covered;
    logic [BOUNDS_PER_VIEW-1:0][LINE_W-1:0]     ibounds;
    logic [BOUNDS_PER_VIEW-1:0][LINE_W-1:0]     dbounds;
    logic [AREA_W-1:0]                          i_area;
    logic [AREA_W-1:0]                          d_area;
    verdict_t                                   iv;
    verdict_t                                   dv;
    acc_kind_e                                  kind;

    assign req_line = req_addr[ADDR_W-1:LINE_SHIFT];
    assign covered  = (32'(req_addr) >= COVER_LO) && (32'(req_addr) < COVER_HI);
    assign kind     = acc_kind_e'(req_kind);

    // ascending boundary order per view
    assign ibounds[0] = line_val[SLOT_ILO];
    assign ibounds[1] = line_val[SLOT_IHI];
    assign ibounds[2] = line_val[SLOT_SHARE];
    assign dbounds[0] = line_val[SLOT_SHARE];
    assign dbounds[1] = line_val[SLOT_DLO];
    assign dbounds[2] = line_val[SLOT_DHI];

    spg_area_sel #(.LINE_W(LINE_W), .NUM_BOUND(BOUNDS_PER_VIEW)) u_isel (
        .addr_line (req_line),
        .bounds    (ibounds),
        .area      (i_area)
    );

    spg_area_sel #(.LINE_W(LINE_W), .NUM_BOUND(BOUNDS_PER_VIEW)) u_dsel (
        .addr_line (req_line),
        .bounds    (dbounds),
        .area      (d_area)
    );

    always_comb begin
        iv.area    = i_area;
        iv.granted = (kind == ACC_RSVD) ? 1'b0 : iperm_val[i_area][req_kind];
        dv.area    = d_area;
        dv.granted = kind_is_data_legal(kind) ? dperm_val[d_area][req_kind[0]] : 1'b0;
    end

    always_comb begin
        if (!covered)
            req_allow = 1'b1;
        else if (acc_view_e'(req_space) == VIEW_INSTR)
            req_allow = iv.granted;
        else
            req_allow = dv.granted;
    end

    // ---------------- configuration read ----------------
    logic [SLOT_W-1:0] rd_slot;
    logic              rd_is_line;

    assign rd_slot    = SLOT_W'(cfg_addr - IDX_LINE_FIRST);
    assign rd_is_line = (cfg_addr >= IDX_LINE_FIRST) && (cfg_addr <= IDX_LINE_LAST);

    always_comb begin
        cfg_rdata = '0;
        if (rd_is_line) begin
            cfg_rdata[LREG_W-1:0] = {line_val[rd_slot], cat_val[rd_slot]};
        end else begin
            case (cfg_addr)
                IDX_SPLIT_LOCK: cfg_rdata[0] = split_lock;
                IDX_PERM_LOCK:  cfg_rdata[0] = perm_lock;
                IDX_PERM_INSTR: cfg_rdata[NUM_AREA*IPERM_W-1:0] = iperm_val;
                IDX_PERM_DATA:  cfg_rdata[NUM_AREA*DPERM_W-1:0] = dperm_val;
                default:        cfg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/spg_guard_chk.sv
module spg_guard_chk
    import spg_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int LINE_SHIFT = 9,
    parameter int RSV_BYTES  = 16384,
    parameter int SEG_BYTES  = 131072,
    parameter int NUM_SEG    = 3,
    localparam int LINE_W    = ADDR_W - LINE_SHIFT
)(
    input logic                          clk,
    input logic                          rst,
    input logic                          cfg_we,
    input logic [REG_IDX_W-1:0]          cfg_addr,
    input logic                          cfg_wbit0,
    input logic [ADDR_W-1:0]             req_addr,
    input logic                          req_space,
    input logic [1:0]                    req_kind,
    input logic                          req_allow,
    input logic                          split_lock,
    input logic                          perm_lock,
    input logic [NUM_LINES*LINE_W-1:0]   lines_flat,
    input logic [NUM_AREA*IPERM_W-1:0]   iperm_flat,
    input logic [NUM_AREA*DPERM_W-1:0]   dperm_flat
);

    logic in_window;
    assign in_window = (32'(req_addr) >= 32'(RSV_BYTES)) &&
                       (32'(req_addr) < 32'(RSV_BYTES + NUM_SEG * SEG_BYTES));

    assert_uncovered_pass_R7: assert property (@(posedge clk) disable iff (rst)
        !in_window |-> req_allow);

    assert_data_fetch_deny_R6: assert property (@(posedge clk) disable iff (rst)
        (in_window && req_space && (req_kind == 2'd2)) |-> !req_allow);

    assert_rsvd_kind_deny_R6: assert property (@(posedge clk) disable iff (rst)
        (in_window && (req_kind == 2'd3)) |-> !req_allow);

    assert_split_lock_set_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (cfg_addr == IDX_SPLIT_LOCK) && cfg_wbit0) |=> split_lock);

    assert_perm_lock_set_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (cfg_addr == IDX_PERM_LOCK) && cfg_wbit0) |=> perm_lock);

    assert_split_lock_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        split_lock |=> split_lock);

    assert_perm_lock_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        perm_lock |=> perm_lock);

    assert_lines_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        split_lock |=> $stable(lines_flat));

    assert_perms_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        perm_lock |=> ($stable(iperm_flat) && $stable(dperm_flat)));

endmodule

bind sram_perm_guard spg_guard_chk #(
    .ADDR_W     (ADDR_W),
    .LINE_SHIFT (LINE_SHIFT),
    .RSV_BYTES  (RSV_BYTES),
    .SEG_BYTES  (SEG_BYTES),
    .NUM_SEG    (NUM_SEG)
) u_guard_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wbit0  (cfg_wdata[0]),
    .req_addr   (req_addr),
    .req_space  (req_space),
    .req_kind   (req_kind),
    .req_allow  (req_allow),
    .split_lock (split_lock),
    .perm_lock  (perm_lock),
    .lines_flat (line_val),
    .iperm_flat (iperm_val),
    .dperm_flat (dperm_val)
);

// File: tb/sram_perm_guard_bench.sv
module sram_perm_guard_bench;

    localparam int AW = 20;
    localparam int LO = 16384;
    localparam int HI = 16384 + 3 * 131072;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [AW-1:0] req_addr = '0;
    logic        req_space = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        req_allow;

    int n_checks = 0;
    int n_err    = 0;

    // bench-side expected configuration
    int         m_line [5];
    logic [5:0] m_cat  [5];
    logic [2:0] m_ip   [4];
    logic [1:0] m_dp   [4];
    logic       m_slock, m_plock;

    always #4 clk = ~clk;

    sram_perm_guard u_sram_perm_guard (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_addr(req_addr),
        .req_space(req_space), .req_kind(req_kind), .req_allow(req_allow)
    );

    function automatic logic [5:0] spec_cats(input int ln);
        logic [5:0] c;
        int pos;
        pos = ln * 512;
        for (int s = 0; s < 3; s++) begin
            int lo;
            lo = LO + s * 131072;
            if (pos >= lo + 131072)  c[2*s +: 2] = 2'd0;
            else if (pos >= lo)      c[2*s +: 2] = 2'd2;
            else                     c[2*s +: 2] = 2'd3;
        end
        return c;
    endfunction

    function automatic logic [31:0] exp_read(input int idx);
        logic [31:0] r;
        r = '0;
        if (idx == 0) r[0] = m_slock;
        else if (idx >= 1 && idx <= 5) r = (32'(m_line[idx-1]) << 6) | 32'(m_cat[idx-1]);
        else if (idx == 6) r[0] = m_plock;
        else if (idx == 7) for (int n = 0; n < 4; n++) r[3*n +: 3] = m_ip[n];
        else if (idx == 8) for (int n = 0; n < 4; n++) r[2*n +: 2] = m_dp[n];
        return r;
    endfunction

    function automatic logic exp_allow(input int a, input logic sp, input int k);
        int ln, area;
        int b [3];
        if (a < LO || a >= HI) return 1'b1;
        ln = a / 512;
        if (!sp) begin b[0] = m_line[1]; b[1] = m_line[2]; b[2] = m_line[0]; end
        else     begin b[0] = m_line[0]; b[1] = m_line[3]; b[2] = m_line[4]; end
        area = 0;
        for (int i = 0; i < 3; i++) if (ln >= b[i]) area++;
        if (!sp) return (k == 3) ? 1'b0 : m_ip[area][k];
        return (k >= 2) ? 1'b0 : m_dp[area][k];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 5; i++) begin m_line[i] = 0; m_cat[i] = '0; end
        for (int n = 0; n < 4; n++) begin m_ip[n] = '0; m_dp[n] = '0; end
        m_slock = 1'b0;
        m_plock = 1'b0;
    endtask

    task automatic model_apply(input int idx, input logic [31:0] d);
        int ln;
        if (idx == 0 && d[0]) m_slock = 1'b1;
        if (idx == 6 && d[0]) m_plock = 1'b1;
        if (idx >= 1 && idx <= 5 && !m_slock) begin
            ln = int'(d[16:6]);
            if (ln * 512 >= LO && ln * 512 < HI) begin
                m_line[idx-1] = ln;
                m_cat[idx-1]  = spec_cats(ln);
            end
        end
        if (idx == 7 && !m_plock) for (int n = 0; n < 4; n++) m_ip[n] = d[3*n +: 3];
        if (idx == 8 && !m_plock) for (int n = 0; n < 4; n++) m_dp[n] = d[2*n +: 2];
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic cfg_write(input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 4'(idx);
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
        model_apply(idx, d);
    endtask

    task automatic read_check(input int idx, input string tag);
        @(negedge clk);
        cfg_addr = 4'(idx);
        #1;
        check(tag, cfg_rdata, exp_read(idx));
    endtask

    task automatic acc_check(input int a, input logic sp, input int k, input string tag);
        @(negedge clk);
        req_addr  = AW'(a);
        req_space = sp;
        req_kind  = 2'(k);
        #1;
        check(tag, 32'(req_allow), 32'(exp_allow(a, sp, k)));
    endtask

    function automatic logic [31:0] line_word(input int byte_off);
        return 32'(byte_off / 512) << 6 | 32'h3F;   // junk category bits
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin : main
        logic [31:0] iw, dw;
        model_reset();
        do_reset();

        // R1 / R11: reset image of every index
        for (int i = 0; i < 16; i++) read_check(i, (i < 9) ? "R1 reset read" : "R11 unused read");
        acc_check(32'h10000, 1'b0, 0, "R1 covered load denied after reset");
        acc_check(32'h50000, 1'b1, 1, "R1 covered store denied after reset");

        // R2 / R3: exhaustive line sweep on the shared boundary
        for (int ln = 0; ln < 2048; ln++) begin
            cfg_write(1, (32'(ln) << 6) | 32'h2A);
            read_check(1, "R2 R3 shared line sweep");
        end

        // boundaries: instr 0x10000/0x30000/shared 0x40000, data 0x50000/0x60000
        cfg_write(1, line_word(32'h40000));
        cfg_write(2, line_word(32'h10000));
        cfg_write(3, line_word(32'h30000));
        cfg_write(4, line_word(32'h50000));
        cfg_write(5, line_word(32'h60000));
        for (int i = 1; i <= 5; i++) read_check(i, "R3 category codes");

        // R2: out-of-range targets dropped
        cfg_write(4, line_word(32'h2000));
        read_check(4, "R2 reserved-window target ignored");
        cfg_write(5, line_word(32'h70000));
        read_check(5, "R2 above-range target ignored");
        cfg_write(4, line_word(32'h63E00));
        read_check(4, "R2 last line of segment 2 accepted");
        cfg_write(4, line_word(32'h50000));

        // R11: unassigned index write
        cfg_write(12, 32'hFFFF_FFFF);
        read_check(12, "R11 unused index write ignored");
        read_check(7, "R11 perms untouched by unused write");

        // R4 R5 R6 R7: sweep permission patterns, addresses, views and kinds
        for (int p = 0; p < 8; p++) begin
            iw = '0;
            dw = '0;
            for (int n = 0; n < 4; n++) begin
                iw[3*n +: 3] = 3'((p + 3 * n) % 8);
                dw[2*n +: 2] = 2'((p + n) % 4);
            end
            cfg_write(7, iw);
            cfg_write(8, dw);
            read_check(7, "R5 instr perm read");
            read_check(8, "R5 data perm read");
            for (int a = 0; a < (1 << AW); a += 32'h800) begin
                for (int sp = 0; sp < 2; sp++) begin
                    for (int k = 0; k < 4; k++) begin
                        acc_check(a, sp[0], k, "R4 R6 R7 verdict at line start");
                        if (a > 0) acc_check(a - 1, sp[0], k, "R4 R6 verdict at prior byte");
                    end
                end
            end
        end

        // R10: same-cycle write and access
        cfg_write(7, 32'h0);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 4'd7;
        cfg_wdata = 32'hFFF;
        req_addr  = AW'(32'h20000);
        req_space = 1'b0;
        req_kind  = 2'd0;
        #1;
        check("R10 old verdict before edge", 32'(req_allow), 32'd0);
        @(posedge clk);
        #1;
        check("R10 new verdict after edge", 32'(req_allow), 32'd1);
        @(negedge clk);
        cfg_we = 1'b0;
        model_apply(7, 32'hFFF);

        // R8 / R9: locks
        cfg_write(0, 32'h0);
        read_check(0, "R8 writing zero leaves lock clear");
        cfg_write(0, 32'h1);
        read_check(0, "R8 boundary lock reads one");
        cfg_write(1, line_word(32'h20000));
        read_check(1, "R9 locked boundary write ignored");
        acc_check(32'h3FFFF, 1'b1, 0, "R9 verdict keeps locked boundary");
        cfg_write(8, 32'h0F);
        read_check(8, "R9 perms writable under boundary lock");
        cfg_write(0, 32'h0);
        read_check(0, "R8 boundary lock sticky");
        cfg_write(6, 32'h1);
        read_check(6, "R8 perm lock reads one");
        cfg_write(7, 32'h000);
        read_check(7, "R9 locked perm write ignored");
        acc_check(32'h20000, 1'b0, 2, "R9 fetch still allowed under perm lock");
        cfg_write(6, 32'h0);
        read_check(6, "R8 perm lock sticky");

        // R1: reset clears locks
        do_reset();
        read_check(0, "R1 reset clears boundary lock");
        read_check(6, "R1 reset clears perm lock");

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule